// File: doc/BRIEF.md
# Linked Dual Counter with Capture Clear

This block holds two 16-bit up-counters driven by one clock. Each counter has its own capture input, its own capture register and its own control field. The control field picks which edge of the capture input is sampled and what may clear the counter. A single link bit couples the two counters. When the link bit is set, a software write to either counter loads both. A counter set to follow its partner is then cleared in the same cycle as the partner, whichever of the two clears first.

A typical use is period measurement. Counter 0 captures its value on a rising input edge and clears on that capture. Counter 1 is set to follow, so both restart from zero together and both stay aligned to the same reference edge.

Software reaches the block through a one-cycle write port. Address 0 is counter 0 and address 1 is counter 1. Address 2 is the control field of counter 0 and address 3 is the control field of counter 1. Address 4 holds the link bit in data bit 0. In a control field, data bits [2:0] are the clear source and data bits [5:3] are the edge select. Both counters and both capture registers can be read at all times on dedicated outputs.

Top module: `dual_sync_counter`

## Requirements
- R1: After reset both counters, both capture registers, both control fields and the link bit are zero.
- R2: With the link bit at 0, a write to address 0 or 1 loads wr_data only into the addressed counter. The new value is visible after the next clock edge.
- R3: With the link bit at 1, a write to address 0 or to address 1 loads wr_data into both counters on the same edge.
- R4: A counter that is neither cleared nor written holds its value while cnt_en is low. While cnt_en is high it adds one per clock and wraps from FFFFh to 0000h. A write takes precedence over the increment.
- R5: The edge select in control bits [5:3] picks the capture event: 100b is a rising edge, 101b a falling edge and 110b either edge. Any other value captures nothing. The capture input passes through two synchronizing flops and an edge detector. An input change made just after clock edge k loads the capture register at edge k+3 with the counter value held just before that edge.
- R6: Clear source 001b (control bits [2:0]) clears the counter to 0000h on the same edge that loads its capture register.
- R7: Clear source 011b with the link bit at 1 clears the counter on the same edge as its partner's capture clear. This works from counter 0 to counter 1 and from counter 1 to counter 0. With the link bit at 0, setting 011b has no effect.
- R8: Clear source values other than 001b and 011b let the counter run freely. A capture still loads the capture register but does not clear the counter.
- R9: A clear and a software write on the same edge leave the counter at 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both counters |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable for both counters |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 3 | Write address (0, 1 counters; 2, 3 controls; 4 link) |
| wr_data | input | 16 | Write data |
| cap_in | input | 2 | Capture inputs, bit i for counter i, asynchronous |
| cnt0 | output | 16 | Counter 0 value |
| cnt1 | output | 16 | Counter 1 value |
| cap0 | output | 16 | Capture register of counter 0 |
| cap1 | output | 16 | Capture register of counter 1 |

## Verification
The assertions assume that wr_en is a clean one-cycle strobe whose address and data are stable at the clock edge. They also assume the capture inputs change only away from the sampling edge, so that the two synchronizing flops see one defined level per cycle. The bench drives every input on the falling clock edge. After each capture input change it waits three clock cycles, so the synchronizer has settled before the next change. It reconfigures an edge select only while the matching input is idle. A clear and a write are made to coincide by placing the write exactly on the edge where the synchronized capture pulse is present.

// File: rtl/dual_sync_counter.sv
module dual_sync_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   cap_in,
  output logic [W-1:0] cnt0,
  output logic [W-1:0] cnt1,
  output logic [W-1:0] cap0,
  output logic [W-1:0] cap1
);

  localparam logic [2:0] CS_CAPCLR = 3'b001;
  localparam logic [2:0] CS_FOLLOW = 3'b011;
  localparam logic [2:0] ES_RISE   = 3'b100;
  localparam logic [2:0] ES_FALL   = 3'b101;
  localparam logic [2:0] ES_BOTH   = 3'b110;
  localparam logic [2:0] A_LINK    = 3'd4;

  logic         link_on;
  logic [5:0]   ctrl   [2];
  logic [2:0]   sy     [2];
  logic [W-1:0] cnt    [2];
  logic [W-1:0] capr   [2];
  logic [1:0]   cap_evt, own, link, clr, load;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      case (ctrl[i][5:3])
        ES_RISE: cap_evt[i] =  sy[i][1] & ~sy[i][2];
        ES_FALL: cap_evt[i] = ~sy[i][1] &  sy[i][2];
        ES_BOTH: cap_evt[i] =  sy[i][1] ^  sy[i][2];
        default: cap_evt[i] = 1'b0;
      endcase
      own[i]  = cap_evt[i] & (ctrl[i][2:0] == CS_CAPCLR);
      link[i] = link_on & (ctrl[i][2:0] == CS_FOLLOW);
      load[i] = wr_en & ((wr_addr == 3'(i)) | (link_on & (wr_addr[2:1] == 2'b00)));
    end
  end

  assign clr[0] = own[0] | (link[0] & own[1]);
  assign clr[1] = own[1] | (link[1] & own[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_on <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        ctrl[i] <= '0;
        sy[i]   <= '0;
        cnt[i]  <= '0;
        capr[i] <= '0;
      end
    end else begin
      if (wr_en && wr_addr == A_LINK) link_on <= wr_data[0];
      for (int i = 0; i < 2; i++) begin
        if (wr_en && wr_addr == 3'(i + 2)) ctrl[i] <= wr_data[5:0];
        sy[i] <= {sy[i][1:0], cap_in[i]};
        if (cap_evt[i]) capr[i] <= cnt[i];
        if (clr[i])       cnt[i] <= '0;
        else if (load[i]) cnt[i] <= wr_data;
        else if (cnt_en)  cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  assign cnt0 = cnt[0];
  assign cnt1 = cnt[1];
  assign cap0 = capr[0];
  assign cap1 = capr[1];

endmodule

// File: rtl/dual_sync_counter_chk.sv
module dual_sync_counter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         wr_en,
  input logic [2:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] cnt0,
  input logic [W-1:0] cnt1,
  input logic [W-1:0] cap0,
  input logic         link_on,
  input logic [1:0]   cap_evt,
  input logic [1:0]   link,
  input logic [1:0]   clr
);

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr[0] |=> cnt0 == '0); // R6

  AST_CAPTURE_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt[0] |=> cap0 == $past(cnt0)); // R5

  AST_LINKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && link_on && wr_addr[2:1] == 2'b00 && clr == 2'b00)
      |=> (cnt0 == $past(wr_data) && cnt1 == $past(wr_data))); // R3

  AST_FOLLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (link[1] && clr[0]) |=> cnt1 == '0); // R7

  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !wr_en && clr[0] == 1'b0 && cnt0 == '1) |=> cnt0 == '0); // R4

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_en && clr[0] == 1'b0) |=> $stable(cnt0)); // R4

endmodule

bind dual_sync_counter dual_sync_counter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .cnt0(cnt0), .cnt1(cnt1),
  .cap0(cap0), .link_on(link_on), .cap_evt(cap_evt), .link(link), .clr(clr)
);

// File: tb/sim_dual_sync_counter.sv
module sim_dual_sync_counter;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  cap_in = '0;
  logic [15:0] cnt0, cnt1, cap0, cap1;
  int checks = 0, failures = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_sync_counter u0 (.*);

  typedef struct packed {
    logic we; logic [2:0] addr; logic [15:0] data; logic en;
    logic [15:0] e0; logic [15:0] e1;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b1, 3'd0, 16'h1234, 1'b0, 16'h1234, 16'h0000},
    '{1'b1, 3'd1, 16'h00FF, 1'b0, 16'h1234, 16'h00FF},
    '{1'b1, 3'd4, 16'h0001, 1'b0, 16'h1234, 16'h00FF},
    '{1'b1, 3'd0, 16'hABCD, 1'b0, 16'hABCD, 16'hABCD},
    '{1'b1, 3'd1, 16'h0005, 1'b0, 16'h0005, 16'h0005},
    '{1'b0, 3'd0, 16'h0000, 1'b1, 16'h0006, 16'h0006},
    '{1'b1, 3'd0, 16'hFFFF, 1'b1, 16'hFFFF, 16'hFFFF},
    '{1'b0, 3'd0, 16'h0000, 1'b1, 16'h0000, 16'h0000},
    '{1'b1, 3'd4, 16'h0000, 1'b0, 16'h0000, 16'h0000},
    '{1'b1, 3'd1, 16'h7777, 1'b0, 16'h0000, 16'h7777}
  };
  localparam string VREQ [10] = '{"R2", "R2", "R4", "R3", "R3", "R4", "R4", "R4", "R4", "R2"};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 5000);
    failures++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cnt0", cnt0, 16'h0); chk("R1 cnt1", cnt1, 16'h0);
    chk("R1 cap0", cap0, 16'h0); chk("R1 cap1", cap1, 16'h0);

    foreach (VEC[k]) begin
      wr_en = VEC[k].we; wr_addr = VEC[k].addr; wr_data = VEC[k].data; cnt_en = VEC[k].en;
      @(negedge clk);
      wr_en = 1'b0; cnt_en = 1'b0;
      chk({VREQ[k], " vec cnt0"}, cnt0, VEC[k].e0);
      chk({VREQ[k], " vec cnt1"}, cnt1, VEC[k].e1);
    end

    // R6 R7: counter 0 captures and clears, counter 1 follows
    wr(3'd2, 16'h0021); wr(3'd3, 16'h0003); wr(3'd4, 16'h0001);
    wr(3'd0, 16'h0100);
    cnt_en = 1'b1; cap_in[0] = 1'b1;
    settle();
    cnt_en = 1'b0;
    chk("R6 cap0 old value", cap0, 16'h0102);
    chk("R6 cnt0 cleared", cnt0, 16'h0000);
    chk("R7 cnt1 follows 0", cnt1, 16'h0000);

    // R7 reverse direction
    cap_in[0] = 1'b0; settle();
    wr(3'd2, 16'h0003); wr(3'd3, 16'h0021);
    wr(3'd1, 16'h0200);
    chk("R3 link via addr1 cnt0", cnt0, 16'h0200);
    cap_in[1] = 1'b1; settle();
    chk("R5 cap1", cap1, 16'h0200);
    chk("R6 cnt1 cleared", cnt1, 16'h0000);
    chk("R7 cnt0 follows 1", cnt0, 16'h0000);

    // R7: link off, follow has no effect
    wr(3'd4, 16'h0000); wr(3'd2, 16'h0021); wr(3'd3, 16'h0003);
    wr(3'd0, 16'h0050); wr(3'd1, 16'h0060);
    cap_in[0] = 1'b1; settle();
    chk("R6 cnt0 cleared unlinked", cnt0, 16'h0000);
    chk("R7 cnt1 untouched unlinked", cnt1, 16'h0060);
    chk("R5 cap0 unlinked", cap0, 16'h0050);

    // R9: clear and write on one edge
    cap_in[0] = 1'b0; settle();
    chk("R5 no capture on fall with rise select", cap0, 16'h0050);
    wr(3'd0, 16'h0040);
    cap_in[0] = 1'b1;
    repeat (2) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h0099;
    @(negedge clk); wr_en = 1'b0;
    chk("R9 clear beats write", cnt0, 16'h0000);
    chk("R5 cap0 before clear", cap0, 16'h0040);

    // R5: falling edge select, no clear
    wr(3'd2, 16'h0028); wr(3'd0, 16'h0033);
    cap_in[0] = 1'b0; settle();
    chk("R5 falling capture", cap0, 16'h0033);
    chk("R8 cnt0 kept (source 000)", cnt0, 16'h0033);

    // R8: unused clear source acts as free run
    wr(3'd2, 16'h0022); wr(3'd0, 16'h0044);
    cap_in[0] = 1'b1; settle();
    chk("R8 capture without clear", cap0, 16'h0044);
    chk("R8 cnt0 free run", cnt0, 16'h0044);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule